// File: doc/BRIEF.md
# Pixel Hit Time-Stamp Readout Array

This block sits at the edge of a pixel sensor. It holds one small readout cell for every pixel. Each pixel delivers an already discriminated hit flag. When that flag goes from low to high, the pixel's cell records the current value of a shared, free-running time-stamp counter and raises its pending flag. The recorded value stays in the cell until the cell is read.

A fixed-priority scanner looks at all pending cells and always points at the one with the smallest linear index, which is `row * N_COLS + col`. Each cycle in which the read strobe is high and some cell is pending, the block does two things at the same clock edge: it registers one output word and clears the cell that was served. The word holds the row address, the column address and the stored time stamp. There is no trigger. Hits drain continuously, in priority order, at one word per read cycle.

Top module: `pxro_top`

## Requirements
- R1: While reset is high, at the next edge the block clears every pending flag, drops `dout_vld_o` to 0, sets `ts_o` to 0 and sets `dout_o` to 0.
- R2: `ts_o` rises by one on every clock edge after reset and wraps from 2^TS_W-1 to 0. TS_W defaults to 10.
- R3: A rising hit flag on a free cell, seen at a clock edge, stores the value `ts_o` showed in the cycle before that edge and marks the cell pending.
- R4: A hit flag that stays high does not cause a second capture, and a pending cell keeps its data until it is read.
- R5: A new rising hit flag on a cell that is already pending is ignored, and the first stored time stamp is kept.
- R6: A read cycle with at least one cell pending serves the pending cell with the lowest linear index `row*N_COLS+col`. The word appears on `dout_o` one cycle later with `dout_vld_o` high. The word is laid out as {row, col, time stamp}: the row sits in the top bits and the time stamp in the lowest TS_W bits.
- R7: Each read cycle yields at most one word, and the served cell is no longer pending after that same edge.
- R8: A read cycle with no cell pending, or any cycle without a read, leaves `dout_vld_o` low on the next cycle and `dout_o` unchanged.
- R9: `pend_any_o` is high exactly when at least one cell is pending.
- R10: A rising hit flag on the cell being served in the same cycle is ignored, so that cell ends up free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | N_ROWS*N_COLS | Discriminated hit flag per pixel; bit index is row*N_COLS+col |
| rd_i | input | 1 | Read strobe: serve one pending cell this cycle |
| ts_o | output | TS_W | Current time-stamp counter value |
| pend_any_o | output | 1 | At least one cell is pending |
| dout_vld_o | output | 1 | `dout_o` holds a word served by the previous read cycle |
| dout_o | output | RW+CW+TS_W | {row, col, time stamp} of the served cell |

## Verification
The hardest cases to reach from the ports are both timing collisions:
- a cell gets a second rising edge while it is still pending, which needs a fall followed by a new rise before any read;
- a rising edge lands on the very cell being served in that cycle.

Directed sequences build both cases on purpose. They also build a case with two simultaneous pending cells, to check the priority order. Seeded random toggling of the hit flags and of the read strobe then covers mixed occupancy over more than one counter wrap. A cycle-level model in the bench predicts every word.

// File: rtl/pxro_pkg.sv
package pxro_pkg;

    // Address width for a count of items, never below one bit.
    function automatic int idx_w(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    localparam int DEF_ROWS = 4;
    localparam int DEF_COLS = 8;
    localparam int DEF_TS_W = 10;

endpackage

// File: rtl/pxro_tsgen.sv
module pxro_tsgen #(
    parameter int TS_W = pxro_pkg::DEF_TS_W
) (
    input  logic            clk,
    input  logic            rst,
    output logic [TS_W-1:0] ts_o
);
    always_ff @(posedge clk) begin
        if (rst) ts_o <= '0;
        else     ts_o <= ts_o + 1'b1;
    end
endmodule

// File: rtl/pxro_cell.sv
module pxro_cell #(
    parameter int TS_W = pxro_pkg::DEF_TS_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hit_i,
    input  logic [TS_W-1:0] ts_i,
    input  logic            clr_i,
    output logic            pend_o,
    output logic [TS_W-1:0] ts_o
);
    logic hit_q;
    logic rise;

    assign rise = hit_i & ~hit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q  <= 1'b0;
            pend_o <= 1'b0;
            ts_o   <= '0;
        end else begin
            hit_q <= hit_i;
            if (clr_i) begin
                pend_o <= 1'b0;
            end else if (rise && !pend_o) begin
                pend_o <= 1'b1;
                ts_o   <= ts_i;
            end
        end
    end
endmodule

// File: rtl/pxro_prio.sv
module pxro_prio #(
    parameter int N  = 32,
    parameter int IW = pxro_pkg::idx_w(N)
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o,
    output logic [N-1:0]  gnt_o
);
    logic [IW-1:0] pick;

    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) pick = IW'(i);
        end
    end

    always_comb begin
        gnt_o = '0;
        if (|req_i) gnt_o[pick] = 1'b1;
    end

    assign any_o = |req_i;
    assign idx_o = pick;
endmodule

// File: rtl/pxro_top.sv
module pxro_top #(
    parameter int N_ROWS = pxro_pkg::DEF_ROWS,
    parameter int N_COLS = pxro_pkg::DEF_COLS,
    parameter int TS_W   = pxro_pkg::DEF_TS_W
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [N_ROWS*N_COLS-1:0]              hit_i,
    input  logic                                  rd_i,
    output logic [TS_W-1:0]                       ts_o,
    output logic                                  pend_any_o,
    output logic                                  dout_vld_o,
    output logic [pxro_pkg::idx_w(N_ROWS)+pxro_pkg::idx_w(N_COLS)+TS_W-1:0] dout_o
);
    localparam int N_PIX = N_ROWS * N_COLS;
    localparam int IW    = pxro_pkg::idx_w(N_PIX);
    localparam int RW    = pxro_pkg::idx_w(N_ROWS);
    localparam int CW    = pxro_pkg::idx_w(N_COLS);
    localparam int DW    = RW + CW + TS_W;

    logic [N_PIX-1:0] pend;
    logic [N_PIX-1:0] gnt;
    logic [N_PIX-1:0] clr;
    logic [TS_W-1:0]  cell_ts [N_PIX];
    logic             any;
    logic [IW-1:0]    sel_idx;
    logic [RW-1:0]    sel_row;
    logic [CW-1:0]    sel_col;
    logic [TS_W-1:0]  sel_ts;
    logic             serve;

    pxro_tsgen #(.TS_W(TS_W)) u_ts (
        .clk  (clk),
        .rst  (rst),
        .ts_o (ts_o)
    );

    for (genvar p = 0; p < N_PIX; p++) begin : g_cell
        pxro_cell #(.TS_W(TS_W)) u_cell (
            .clk    (clk),
            .rst    (rst),
            .hit_i  (hit_i[p]),
            .ts_i   (ts_o),
            .clr_i  (clr[p]),
            .pend_o (pend[p]),
            .ts_o   (cell_ts[p])
        );
    end

    pxro_prio #(.N(N_PIX), .IW(IW)) u_prio (
        .req_i (pend),
        .any_o (any),
        .idx_o (sel_idx),
        .gnt_o (gnt)
    );

    assign serve = rd_i & any;
    assign clr   = serve ? gnt : '0;

    always_comb begin
        sel_row = RW'(int'(sel_idx) / N_COLS);
        sel_col = CW'(int'(sel_idx) % N_COLS);
        sel_ts  = cell_ts[sel_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_vld_o <= 1'b0;
            dout_o     <= '0;
        end else begin
            dout_vld_o <= serve;
            if (serve) dout_o <= DW'({sel_row, sel_col, sel_ts});
        end
    end

    assign pend_any_o = any;
endmodule

// File: rtl/pxro_chk.sv
module pxro_chk #(
    parameter int N_PIX = 32,
    parameter int TS_W  = 10,
    parameter int DW    = 15
) (
    input logic             clk,
    input logic             rst,
    input logic [N_PIX-1:0] hit_i,
    input logic             rd_i,
    input logic [TS_W-1:0]  ts_o,
    input logic             pend_any_o,
    input logic             dout_vld_o,
    input logic [DW-1:0]    dout_o
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!dout_vld_o && !pend_any_o && ts_o == '0));

    a_r2_ts_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ts_o == TS_W'($past(ts_o) + 1'b1));

    a_r4_pending_held: assert property (@(posedge clk) disable iff (rst)
        (!rd_i && pend_any_o) |=> pend_any_o);

    a_r6_word_on_read: assert property (@(posedge clk) disable iff (rst)
        (rd_i && pend_any_o) |=> dout_vld_o);

    a_r8_idle_no_word: assert property (@(posedge clk) disable iff (rst)
        !(rd_i && pend_any_o) |=> (!dout_vld_o && $stable(dout_o)));

    a_r9_idle_no_pend: assert property (@(posedge clk) disable iff (rst)
        (!pend_any_o && hit_i == '0) |=> !pend_any_o);
endmodule

bind pxro_top pxro_chk #(
    .N_PIX (N_ROWS*N_COLS),
    .TS_W  (TS_W),
    .DW    (pxro_pkg::idx_w(N_ROWS)+pxro_pkg::idx_w(N_COLS)+TS_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .hit_i      (hit_i),
    .rd_i       (rd_i),
    .ts_o       (ts_o),
    .pend_any_o (pend_any_o),
    .dout_vld_o (dout_vld_o),
    .dout_o     (dout_o)
);

// File: tb/sim_pxro_top.sv
module sim_pxro_top;
    localparam int ROWS = 4;
    localparam int COLS = 8;
    localparam int TSW  = 10;
    localparam int NP   = ROWS * COLS;
    localparam int RW   = pxro_pkg::idx_w(ROWS);
    localparam int CW   = pxro_pkg::idx_w(COLS);
    localparam int DW   = RW + CW + TSW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] hit = '0;
    logic          rd  = 1'b0;
    logic [TSW-1:0] ts_o;
    logic          pend_any_o;
    logic          dout_vld_o;
    logic [DW-1:0] dout_o;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;
    string cur_tag = "R6";

    // bench model state
    bit             pend_m [NP];
    bit             hp_m   [NP];
    logic [TSW-1:0] ts_m   [NP];
    logic [TSW-1:0] cnt_m;
    bit             exp_v;
    logic [DW-1:0]  exp_d;

    always #5 clk = ~clk;

    pxro_top #(.N_ROWS(ROWS), .N_COLS(COLS), .TS_W(TSW)) u0 (
        .clk(clk), .rst(rst), .hit_i(hit), .rd_i(rd), .ts_o(ts_o),
        .pend_any_o(pend_any_o), .dout_vld_o(dout_vld_o), .dout_o(dout_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit any_m();
        for (int i = 0; i < NP; i++) if (pend_m[i]) return 1;
        return 0;
    endfunction

    task automatic step(input logic [NP-1:0] hv, input logic rv);
        int k;
        hit = hv;
        rd  = rv;
        @(posedge clk);
        k = -1;
        exp_v = 0;
        if (rv) begin
            for (int i = NP - 1; i >= 0; i--) if (pend_m[i]) k = i;
            if (k >= 0) begin
                exp_v = 1;
                exp_d = {RW'(k / COLS), CW'(k % COLS), ts_m[k]};
            end
        end
        for (int i = 0; i < NP; i++) begin
            if (hv[i] && !hp_m[i] && !pend_m[i]) begin
                pend_m[i] = 1;
                ts_m[i]   = cnt_m;
            end
            hp_m[i] = hv[i];
        end
        if (k >= 0) pend_m[k] = 0;
        cnt_m = cnt_m + 1'b1;
        @(negedge clk);
        chk("R2 ts_o", 32'(ts_o), 32'(cnt_m));
        chk("R9 pend_any_o", 32'(pend_any_o), 32'(any_m()));
        chk(exp_v ? "R6 dout_vld_o" : "R8 dout_vld_o", 32'(dout_vld_o), 32'(exp_v));
        chk(exp_v ? cur_tag : "R8", 32'(dout_o), 32'(exp_d));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        logic [NP-1:0] hv;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NP; i++) begin
            pend_m[i] = 0; hp_m[i] = 0; ts_m[i] = '0;
        end
        cnt_m = '0; exp_v = 0; exp_d = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: state right after reset
        chk("R1 ts_o", 32'(ts_o), 0);
        chk("R1 pend_any_o", 32'(pend_any_o), 0);
        chk("R1 dout_vld_o", 32'(dout_vld_o), 0);
        chk("R1 dout_o", 32'(dout_o), 0);

        // R8: read with nothing pending
        step('0, 1'b1);

        // R3, R6, R7: two simultaneous hits, served lowest index first
        cur_tag = "R3 R6 R7 word";
        hv = '0; hv[9] = 1'b1; hv[2] = 1'b1;
        step(hv, 1'b0);
        // R4: level stays high, no recapture
        cur_tag = "R4 word";
        repeat (4) step(hv, 1'b0);
        cur_tag = "R7 word";
        step(hv, 1'b1);
        step(hv, 1'b1);
        repeat (3) step(hv, 1'b0);
        step(hv, 1'b1);
        step('0, 1'b0);

        // R5: second rise on a pending cell is ignored
        cur_tag = "R5 word";
        hv = '0; hv[3] = 1'b1;
        step(hv, 1'b0);
        step('0, 1'b0);
        step('0, 1'b0);
        step(hv, 1'b0);
        step(hv, 1'b1);
        step('0, 1'b1);

        // R10: rise on the cell being served in the same cycle
        cur_tag = "R10 word";
        hv = '0; hv[NP-1] = 1'b1;
        step(hv, 1'b0);
        step('0, 1'b0);
        step(hv, 1'b1);
        chk("R10 pend_any_o after served rise", 32'(pend_any_o), 0);
        step('0, 1'b1);

        // random mix, spans counter wrap (R2)
        cur_tag = "R6 random word";
        hv = '0;
        for (int c = 0; c < 3000; c++) begin
            for (int i = 0; i < NP; i++)
                if ($urandom_range(15) == 0) hv[i] = ~hv[i];
            step(hv, ($urandom_range(2) == 0));
        end
        cur_tag = "R7 drain word";
        for (int c = 0; c < NP + 2; c++) step('0, 1'b1);
        chk("R7 drained pend_any_o", 32'(pend_any_o), 0);

        done = 1;
        finish_run();
    end
endmodule